// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer Counter

A 16-bit timer counter that advances on a clock-enable tick and restarts itself against an auto-reload limit. A single control word chooses upward, downward or symmetric (up then down) counting, a self-stopping single-shot run, whether update events are suppressed, which causes may raise the update flag, and whether the limit takes effect at once or only at the next update event. Each wrap of the counter, and each software update pulse, forms an update event. This event raises a sticky flag, a one-cycle DMA request and an interrupt output that can be masked.

Software reaches the block through a flat word-addressed port with four registers. Address 0 is the control word, address 1 is the auto-reload value, address 2 is the counter and address 3 is the status. Writes take effect at the clock edge. Reads are combinational from the current address. The block does not divide the tick: a prescaler or trigger logic in front of it produces `tick_i`.

Top module: `updown_timer`

## Requirements
- R1: The counter changes on a clock edge with `tick_i` high only while the run bit (control bit 0) is 1. While that bit is 0, the count holds. Control bits 9:8 are stored and read back with no effect on counting.
- R2: With the mode field (control bits 6:5) at 0 and the direction bit (control bit 4) at 0, each tick takes the count up by one. A tick at or above the auto-reload value returns the count to 0 and forms an overflow event.
- R3: With the mode field at 0 and the direction bit at 1, each tick takes the count down by one. A tick at 0 loads the auto-reload value and forms an underflow event.
- R4: With the mode field at 1, 2 or 3, the count runs 0 up to the auto-reload value and back down to 0. An event forms when the count leaves the top and when it leaves 0. Control bit 4 reads 1 while the count is falling and 0 while it is rising. A control write with a nonzero mode field leaves that bit unchanged.
- R5: With the single-shot bit (control bit 3) at 1, an update event clears the run bit, and counting stops.
- R6: With the update-disable bit (control bit 1) at 1, no update event forms. The buffered limit is not loaded, the flag, DMA request and `upd_evt_o` stay low, and the run bit is not cleared. The counter still wraps.
- R7: With the source bit (control bit 2) at 0, both wraps and `ug_i` set the flag and pulse `dma_req_o`. With the source bit at 1, only wraps do so, while `ug_i` still reloads the counter and the buffered limit.
- R8: With the buffer bit (control bit 7) at 0, a write to address 1 changes the active limit at once. With the buffer bit at 1, the write waits in a preload register until the next update event. Address 1 reads the preload value.
- R9: With control bit 11 at 1, address 2 returns the update flag in bit 31 above the count. With that bit at 0, bit 31 reads 0.
- R10: `ug_i` resets the counter on the next edge, whatever the run bit. In downward edge mode the counter takes the active limit (after any buffered load in that edge). Otherwise it takes 0, and in symmetric mode the direction returns to rising.
- R11: The update flag (address 3 bit 0) is set one edge after an event and stays set until a write of 0 to that bit. Writing 1 has no effect, and a set in the same edge wins. `irq_o` is the flag ANDed with control bit 12. `upd_evt_o` and `dma_req_o` are one-cycle pulses in the cycle in which the flag is set.
- R12: While the active limit is 0, ticks keep the count at 0 and form no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 control, 1 limit, 2 count, 3 status) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| tick_i | input | 1 | Count enable pulse |
| ug_i | input | 1 | Software update request |
| upd_evt_o | output | 1 | Update event pulse |
| irq_o | output | 1 | Update interrupt |
| dma_req_o | output | 1 | Update DMA request pulse |

## Verification
Counting is driven with a tick on every cycle and with a tick every third cycle. The first pattern exposes off-by-one errors at the wrap points. The second shows whether the counter advances only on ticks rather than on clocks. Each of the four mode values is run from rising and from falling starts, with direction writes slipped in. This separates hardware-owned direction from software-owned direction. Software updates are issued under each source-bit setting and each direction. Limit writes are placed mid-period with the buffer on and off, so an early or late reload shows up as a period of the wrong length.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef struct packed {
    logic       irq_en;
    logic       remap;
    logic       rsvd;
    logic [1:0] clk_div;
    logic       arr_buf;
    logic [1:0] align;
    logic       dir;
    logic       one_shot;
    logic       src_ovf_only;
    logic       upd_dis;
    logic       run;
  } tmr_ctrl_t;

  localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_ARR  = 2'd1,
    ADDR_CNT  = 2'd2,
    ADDR_STAT = 2'd3
  } tmr_addr_e;
endpackage

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic [CNT_W-1:0] ug_arr_i,
  input  logic             ug_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             dir_we_i,
  input  logic             dir_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d, wrap;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    wrap  = 1'b0;
    if (run_i && tick_i && !ug_i) begin
      if (arr_i == '0) begin
        cnt_d = '0;
      end else if (!dir_q) begin
        if (cnt_q >= arr_i) begin
          wrap  = 1'b1;
          cnt_d = center_i ? arr_i - ONE : '0;
          if (center_i) dir_d = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q == '0) begin
          wrap  = 1'b1;
          cnt_d = center_i ? ONE : arr_i;
          if (center_i) dir_d = 1'b0;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
    if (ug_i) begin
      cnt_d = (!center_i && dir_q) ? ug_arr_i : '0;
      if (center_i) dir_d = 1'b0;
    end
    if (cnt_we_i) cnt_d = cnt_wdata_i;
    if (dir_we_i) dir_d = dir_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign dir_o  = dir_q;
  assign wrap_o = wrap;
endmodule

// File: rtl/tmr_arr.sv
`timescale 1ns/1ps
module tmr_arr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             buf_en_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] pre_o,
  output logic [CNT_W-1:0] act_o,
  output logic [CNT_W-1:0] next_act_o
);
  logic [CNT_W-1:0] pre_q, act_q, act_d;

  // value the active limit takes from an update event, before any write
  assign next_act_o = (load_i && buf_en_i) ? pre_q : act_q;

  always_comb begin
    act_d = next_act_o;
    if (we_i && !buf_en_i) act_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      if (we_i) pre_q <= wdata_i;
      act_q <= act_d;
    end
  end

  assign pre_o = pre_q;
  assign act_o = act_q;
endmodule

// File: rtl/tmr_flag.sv
`timescale 1ns/1ps
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic ug_i,
  input  logic upd_dis_i,
  input  logic src_ovf_only_i,
  input  logic clr_we_i,
  input  logic clr_bit_i,
  output logic flag_o,
  output logic dma_o
);
  logic set, flag_q, dma_q;

  assign set = !upd_dis_i && (wrap_i || (ug_i && !src_ovf_only_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      flag_q <= set || (flag_q && !(clr_we_i && !clr_bit_i));
      dma_q  <= set;
    end
  end

  assign flag_o = flag_q;
  assign dma_o  = dma_q;
endmodule

// File: rtl/updown_timer.sv
`timescale 1ns/1ps
module updown_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              tick_i,
  input  logic              ug_i,
  output logic              upd_evt_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  tmr_ctrl_t        ctrl_q, ctrl_wr, ctrl_rd;
  tmr_addr_e        addr;
  logic             ctrl_we, arr_we, cnt_we, stat_we;
  logic             center, wrap, uev, evt_q, dir, flag;
  logic [CNT_W-1:0] cnt, arr_pre, arr_act, arr_next;
  logic             unused_wdata;

  assign addr    = tmr_addr_e'(reg_addr_i);
  assign ctrl_we = reg_we_i && (addr == ADDR_CTRL);
  assign arr_we  = reg_we_i && (addr == ADDR_ARR);
  assign cnt_we  = reg_we_i && (addr == ADDR_CNT);
  assign stat_we = reg_we_i && (addr == ADDR_STAT);
  assign ctrl_wr = tmr_ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
  assign center  = (ctrl_q.align != 2'd0);
  assign uev     = (wrap || ug_i) && !ctrl_q.upd_dis;
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= uev;
      if (ctrl_we) begin
        ctrl_q      <= ctrl_wr;
        ctrl_q.rsvd <= 1'b0;
      end else if (uev && ctrl_q.one_shot) begin
        ctrl_q.run  <= 1'b0;
      end
    end
  end

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .run_i       (ctrl_q.run),
    .center_i    (center),
    .arr_i       (arr_act),
    .ug_arr_i    (arr_next),
    .ug_i        (ug_i),
    .cnt_we_i    (cnt_we),
    .cnt_wdata_i (reg_wdata_i[CNT_W-1:0]),
    .dir_we_i    (ctrl_we && (ctrl_wr.align == 2'd0)),
    .dir_wdata_i (ctrl_wr.dir),
    .cnt_o       (cnt),
    .dir_o       (dir),
    .wrap_o      (wrap)
  );

  tmr_arr #(.CNT_W(CNT_W)) u_arr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (arr_we),
    .wdata_i    (reg_wdata_i[CNT_W-1:0]),
    .buf_en_i   (ctrl_q.arr_buf),
    .load_i     (uev),
    .pre_o      (arr_pre),
    .act_o      (arr_act),
    .next_act_o (arr_next)
  );

  tmr_flag u_flag (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wrap_i         (wrap),
    .ug_i           (ug_i),
    .upd_dis_i      (ctrl_q.upd_dis),
    .src_ovf_only_i (ctrl_q.src_ovf_only),
    .clr_we_i       (stat_we),
    .clr_bit_i      (reg_wdata_i[0]),
    .flag_o         (flag),
    .dma_o          (dma_req_o)
  );

  always_comb begin
    ctrl_rd      = ctrl_q;
    ctrl_rd.dir  = dir;
    ctrl_rd.rsvd = 1'b0;
    reg_rdata_o  = '0;
    unique case (addr)
      ADDR_CTRL: reg_rdata_o = DATA_W'(ctrl_rd);
      ADDR_ARR:  reg_rdata_o = DATA_W'(arr_pre);
      ADDR_CNT: begin
        reg_rdata_o             = DATA_W'(cnt);
        reg_rdata_o[DATA_W-1]   = ctrl_q.remap && flag;
      end
      ADDR_STAT: reg_rdata_o = DATA_W'(flag);
      default:   reg_rdata_o = '0;
    endcase
  end

  assign upd_evt_o = evt_q;
  assign irq_o     = flag && ctrl_q.irq_en;
endmodule

// File: rtl/tmr_chk.sv
`timescale 1ns/1ps
module tmr_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run,
  input logic             upd_dis,
  input logic             one_shot,
  input logic             ug_i,
  input logic             cnt_we,
  input logic             ctrl_we,
  input logic             stat_we,
  input logic             wbit0,
  input logic             uev,
  input logic             flag,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] arr_act,
  input logic             upd_evt_o,
  input logic             dma_req_o
);
  assert_hold_when_stopped_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !ug_i && !cnt_we) |=> $stable(cnt));

  assert_single_shot_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uev && one_shot && !ctrl_we) |=> !run);

  assert_no_event_disabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_dis |=> !upd_evt_o);

  assert_flag_clear_by_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag) |-> $past(stat_we && !wbit0));

  assert_dma_implies_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> flag);

  assert_zero_limit_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_act == '0 && !ug_i) |=> !upd_evt_o);
endmodule

bind updown_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run       (ctrl_q.run),
  .upd_dis   (ctrl_q.upd_dis),
  .one_shot  (ctrl_q.one_shot),
  .ug_i      (ug_i),
  .cnt_we    (cnt_we),
  .ctrl_we   (ctrl_we),
  .stat_we   (stat_we),
  .wbit0     (reg_wdata_i[0]),
  .uev       (uev),
  .flag      (flag),
  .cnt       (cnt),
  .arr_act   (arr_act),
  .upd_evt_o (upd_evt_o),
  .dma_req_o (dma_req_o)
);

// File: tb/updown_timer_tb_top.sv
`timescale 1ns/1ps
module updown_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        tick_i = 1'b0;
  logic        ug_i = 1'b0;
  logic        upd_evt_o, irq_o, dma_req_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  int tick_div = 1;
  int tick_ctr = 0;
  bit rot = 0;
  int rd_sel = 2;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  updown_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .tick_i(tick_i), .ug_i(ug_i),
    .upd_evt_o(upd_evt_o), .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  // behavioural reference model
  int m_ctrl, m_dir, m_cnt, m_pre, m_act, m_flag, m_evt, m_dma;
  int n_ctrl, n_dir, n_cnt, n_pre, n_act, n_flag;
  bit ctr, wrp, uev, setf;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = 0; m_dir = 0; m_cnt = 0; m_pre = 0; m_act = 0;
      m_flag = 0; m_evt = 0; m_dma = 0;
    end else begin
      ctr = ((m_ctrl >> 5) & 3) != 0;
      n_cnt = m_cnt; n_dir = m_dir; wrp = 0;
      if ((m_ctrl & 1) && tick_i && !ug_i) begin
        if (m_act == 0) n_cnt = 0;
        else if (m_dir == 0) begin
          if (m_cnt >= m_act) begin
            wrp = 1;
            if (ctr) begin n_cnt = m_act - 1; n_dir = 1; end else n_cnt = 0;
          end else n_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin
            wrp = 1;
            if (ctr) begin n_cnt = 1; n_dir = 0; end else n_cnt = m_act;
          end else n_cnt = m_cnt - 1;
        end
      end
      uev  = (wrp || ug_i) && !(m_ctrl & 2);
      n_act = (uev && (m_ctrl & 'h80)) ? m_pre : m_act;
      if (ug_i) begin
        n_cnt = (!ctr && m_dir) ? n_act : 0;
        if (ctr) n_dir = 0;
      end
      setf = !(m_ctrl & 2) && (wrp || (ug_i && !(m_ctrl & 4)));
      n_flag = (setf || m_flag) ? 1 : 0;
      n_ctrl = m_ctrl;
      if (uev && (m_ctrl & 8)) n_ctrl = m_ctrl & ~1;
      n_pre = m_pre;
      if (reg_we_i) begin
        case (reg_addr_i)
          2'd0: begin
            n_ctrl = reg_wdata_i & 'h1BFF;
            if (reg_wdata_i[6:5] == 0) n_dir = reg_wdata_i[4];
          end
          2'd1: begin
            n_pre = reg_wdata_i[15:0];
            if (!(m_ctrl & 'h80)) n_act = reg_wdata_i[15:0];
          end
          2'd2: n_cnt = reg_wdata_i[15:0];
          default: if (!reg_wdata_i[0]) n_flag = setf;
        endcase
      end
      m_ctrl = n_ctrl; m_dir = n_dir; m_cnt = n_cnt; m_pre = n_pre; m_act = n_act;
      m_flag = n_flag; m_evt = uev; m_dma = setf;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    logic [31:0] r;
    case (a)
      2'd0: r = 32'((m_ctrl & ~'h10) | (m_dir << 4));
      2'd1: r = 32'(m_pre);
      2'd2: begin r = 32'(m_cnt); r[31] = ((m_ctrl & 'h800) != 0) && (m_flag != 0); end
      default: r = 32'(m_flag);
    endcase
    return r;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("rdata", reg_rdata_o, exp_rd(reg_addr_i));
      chk("upd_evt", 32'(upd_evt_o), 32'(m_evt));
      chk("dma_req", 32'(dma_req_o), 32'(m_dma));
      chk("irq", 32'(irq_o), 32'(m_flag != 0 && (m_ctrl & 'h1000) != 0));
    end
  end

  task automatic drive(input bit we, input logic [1:0] a, input logic [31:0] d, input bit ug);
    @(negedge clk_i); #1;
    tick_ctr++;
    tick_i = (tick_ctr % tick_div) == 0;
    reg_we_i = we; ug_i = ug; reg_wdata_i = d;
    reg_addr_i = we ? a : (rot ? 2'(tick_ctr % 4) : 2'(rd_sel));
  endtask

  task automatic cyc(input int n);
    repeat (n) drive(0, 0, 0, 0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    drive(1, a, d, 0);
  endtask

  task automatic ug(input int n);
    drive(0, 0, 0, 1);
    cyc(n);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cur_req = "reset";
    for (int a = 0; a < 4; a++) begin
      reg_addr_i = 2'(a); #1;
      chk("reset rdata", reg_rdata_o, 32'h0);
    end
    chk("reset outputs", {29'b0, upd_evt_o, irq_o, dma_req_o}, 32'h0);
    #9 rst_ni = 1'b1;
    cyc(2);

    cur_req = "R2"; wr(1, 5); wr(0, 'h1001); cyc(20);
    cur_req = "R11"; wr(3, 1); cyc(2); wr(3, 0); cyc(3);
    cur_req = "R1"; wr(0, 'h1300); cyc(8); tick_div = 3; wr(0, 'h1001); cyc(15); tick_div = 1;
    cur_req = "R3"; wr(0, 'h1011); cyc(15);
    cur_req = "R4"; rot = 1;
    for (int m = 1; m < 4; m++) begin
      wr(0, 'h1001 | (m << 5)); cyc(14);
      wr(0, 'h1011 | (m << 5)); cyc(10);
    end
    rot = 0;
    cur_req = "R8"; wr(0, 'h1081); wr(1, 9); cyc(4); rd_sel = 1; cyc(2); rd_sel = 2; cyc(25);
    wr(0, 'h1001); wr(1, 3); cyc(10);
    cur_req = "R7"; wr(3, 0); wr(0, 'h1005); ug(4); wr(0, 'h1001); wr(3, 0); ug(4);
    cur_req = "R10"; wr(0, 'h1011); cyc(3); ug(3); wr(0, 'h1021); cyc(5); ug(3);
    wr(0, 'h1000); cyc(2); ug(3);
    cur_req = "R6"; wr(0, 'h1083); wr(1, 4); cyc(12); ug(3);
    cur_req = "R5"; wr(0, 'h1009); cyc(12); wr(0, 'h1009); ug(5);
    cur_req = "R9"; wr(0, 'h1801); rd_sel = 2; cyc(10); wr(3, 0); cyc(3);
    cur_req = "R12"; wr(1, 0); wr(0, 'h1011); cyc(8); wr(2, 7); cyc(6);
    wr(0, 'h1021); cyc(5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule